// File: doc/BRIEF.md
# Fuse Block Program and Read Sequencer

This block is a register-mapped slave that guards access to a bank of 32-bit one-time fuse words. Software drives it through a plain single-cycle request port. Reads come back one cycle later with a valid strobe. The fuse contents are held in a behavioural array, and only a window of normal blocks can be reached. A write to a fuse block burns bits: the written word is ORed into what is already stored, and a bit that has been set never clears again.

Burning needs three things together. An unlock key must sit in the key register. The two-stage program supply must be in its on state, with stage A set and stage B clear. The program-enable bit must also be set. Several optional behaviours can apply during a burn. An auto-check compares the stored result with the requested word. A lock-write mode seals a block after a clean burn. Accesses that are refused or fail leave sticky flags in an error register, which software clears with a bit mask.

Supply changes are modelled by a settle counter. While it runs, the block reports busy and refuses fuse accesses.

Top module: `efuse_seq`

## Requirements
- R1: After reset, reading the registers gives: control (0x20) = 0, error (0x24) = 0, key (0x2C) = 0, and supply (0x54) = 0x2, meaning stage B is set and the supply is off.
- R2: Control bits 4:0 read back as written. Bit 0 is read-supply, bit 1 auto-check, bit 2 double-data, bit 3 margin-read and bit 4 lock-write. The key register reads back its low 16 bits. Supply bits 2:0 read back as written: bit 0 stage A, bit 1 stage B, bit 2 program enable.
- R3: A write to the supply register that changes stage A or stage B, or a control write that changes read-supply, starts a settle period of SETTLE_CYC cycles. During that period, supply bit 31 reads 1, a burn is refused with error bit 0, and a fuse read is refused with error bit 3.
- R4: A fuse write is refused, sets error bit 0 and leaves the fuse word unchanged unless all of these hold: the key equals 0x8810, stage A = 1, stage B = 0, program enable = 1, and the block is not busy. Writing 0 to the key blocks burning again.
- R5: An accepted burn ORs the written word into the stored word. Fuse bits never return from 1 to 0.
- R6: If auto-check is set during an accepted burn and the stored result differs from the written word, error bit 2 is set.
- R7: An accepted burn with lock-write set and no auto-check mismatch locks that block. Any later burn to a locked block sets error bit 1 and changes nothing.
- R8: A fuse read with read-supply set and not busy returns the stored word. With read-supply clear, it returns 0 and sets error bit 3.
- R9: Fuse block n sits at 0x1000 + 4*n. Only blocks 72 to 95 exist. Accesses to any other block read 0, change nothing and set no flag.
- R10: A write to the clear register (0x28) clears each error bit whose mask bit is set. A mask with bits 13:0 all set clears every flag. Error bits never clear any other way.
- R11: Every read request is answered by rvalid with the data exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |

## Verification
On every cycle, the assertions check four things: the one-cycle read response, that no stored fuse bit ever falls, that lock bits are sticky, and that a supply-stage change raises busy. They also check that error bits drop only after a clear-register write. The bench scenarios are needed to show which burns are accepted, the OR result, the exact error bit each refusal raises, and the effect of the auto-check and lock modes. The scenarios also cover reads without supply and the silent out-of-window addresses. A fixed-seed random run of burns is checked against a bench model of the fuse words, the locks and the flags.

// File: rtl/efuse_seq.sv
module efuse_seq #(
  parameter int          ADDR_W     = 13,
  parameter int          NBLK       = 24,
  parameter int          BLK_BASE   = 72,
  parameter int          SETTLE_CYC = 8,
  parameter logic [15:0] UNLOCK_KEY = 16'h8810
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata
);
  localparam int IDX_W = (NBLK > 1) ? $clog2(NBLK) : 1;
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam int BLK_W = ADDR_W - 3;
  localparam int OFF_W = ADDR_W - 1;
  localparam logic [BLK_W-1:0] BLK_LO = BLK_W'(BLK_BASE);
  localparam logic [BLK_W-1:0] BLK_HI = BLK_W'(BLK_BASE + NBLK - 1);
  localparam logic [OFF_W-1:0] OFF_CTRL  = OFF_W'('h20);
  localparam logic [OFF_W-1:0] OFF_ERR   = OFF_W'('h24);
  localparam logic [OFF_W-1:0] OFF_CLR   = OFF_W'('h28);
  localparam logic [OFF_W-1:0] OFF_KEY   = OFF_W'('h2C);
  localparam logic [OFF_W-1:0] OFF_SUPPLY = OFF_W'('h54);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC);

  logic [4:0]        en_q;
  logic [3:0]        err_q;
  logic [15:0]       magic_q;
  logic [2:0]        pwr_q;
  logic [CNT_W-1:0]  settle_q;
  logic [31:0]       fuse_q [NBLK];
  logic [NBLK-1:0]   lock_q;
  logic [NBLK*32-1:0] fuse_flat;

  logic busy, wr, rd, win, in_range, prog_ok, mism;
  logic [BLK_W-1:0] blk, blk_rel;
  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] off;
  logic [31:0] merged, rmux;

  assign busy     = settle_q != '0;
  assign wr       = bus_valid & bus_write;
  assign rd       = bus_valid & ~bus_write;
  assign win      = bus_addr[ADDR_W-1];
  assign off      = bus_addr[ADDR_W-2:0];
  assign blk      = bus_addr[ADDR_W-2:2];
  assign in_range = (blk >= BLK_LO) && (blk <= BLK_HI);
  assign blk_rel  = blk - BLK_LO;
  assign idx      = blk_rel[IDX_W-1:0];
  assign prog_ok  = (magic_q == UNLOCK_KEY) && pwr_q[0] && !pwr_q[1] && pwr_q[2] && !busy;
  assign merged   = fuse_q[idx] | bus_wdata;
  assign mism     = en_q[1] && (merged != bus_wdata);

  for (genvar g = 0; g < NBLK; g++) begin : g_flat
    assign fuse_flat[g*32 +: 32] = fuse_q[g];
  end

  always_comb begin
    rmux = '0;
    if (win) begin
      if (in_range && en_q[0] && !busy) rmux = fuse_q[idx];
    end else begin
      case (off)
        OFF_CTRL:   rmux = {27'b0, en_q};
        OFF_ERR:    rmux = {28'b0, err_q};
        OFF_KEY:    rmux = {16'b0, magic_q};
        OFF_SUPPLY: rmux = {busy, 28'b0, pwr_q};
        default:    rmux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= '0;
      err_q      <= '0;
      magic_q    <= '0;
      pwr_q      <= 3'b010;
      settle_q   <= '0;
      lock_q     <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      for (int i = 0; i < NBLK; i++) fuse_q[i] <= '0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rmux;
      if (busy) settle_q <= settle_q - 1'b1;

      if (wr && !win) begin
        case (off)
          OFF_CTRL: begin
            en_q <= bus_wdata[4:0];
            if (bus_wdata[0] != en_q[0]) settle_q <= SETTLE_LD;
          end
          OFF_CLR: err_q <= err_q & ~bus_wdata[3:0];
          OFF_KEY: magic_q <= bus_wdata[15:0];
          OFF_SUPPLY: begin
            pwr_q <= bus_wdata[2:0];
            if (bus_wdata[1:0] != pwr_q[1:0]) settle_q <= SETTLE_LD;
          end
          default: ;
        endcase
      end

      if (wr && win && in_range) begin
        if (!prog_ok)          err_q[0] <= 1'b1;
        else if (lock_q[idx])  err_q[1] <= 1'b1;
        else begin
          fuse_q[idx] <= merged;
          if (mism)            err_q[2] <= 1'b1;
          else if (en_q[4])    lock_q[idx] <= 1'b1;
        end
      end

      if (rd && win && in_range && (!en_q[0] || busy)) err_q[3] <= 1'b1;
    end
  end
endmodule

// File: rtl/efuse_seq_chk.sv
module efuse_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int NBLK   = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rvalid,
  input logic [3:0]        err_q,
  input logic [2:0]        pwr_q,
  input logic              busy,
  input logic [NBLK-1:0]   lock_q,
  input logic [NBLK*32-1:0] fuse_flat
);
  logic sup_wr, clr_wr;
  assign sup_wr = bus_valid && bus_write && (bus_addr == ADDR_W'('h54));
  assign clr_wr = bus_valid && bus_write && (bus_addr == ADDR_W'('h28));

  assert_rvalid_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> bus_rvalid);

  assert_no_fall_R5: assert property (@(posedge clk) disable iff (rst)
    bus_valid |=> ((fuse_flat & $past(fuse_flat)) == $past(fuse_flat)));

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    bus_valid |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  assert_settle_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (sup_wr && (bus_wdata[1:0] != pwr_q[1:0])) |=> busy);

  assert_err_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (($past(err_q) & ~err_q) != 4'b0) |-> $past(clr_wr));
endmodule

bind efuse_seq efuse_seq_chk #(.ADDR_W(ADDR_W), .NBLK(NBLK)) chk_i (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
  .err_q(err_q), .pwr_q(pwr_q), .busy(busy), .lock_q(lock_q),
  .fuse_flat(fuse_flat)
);

// File: tb/efuse_seq_tb.sv
module efuse_seq_tb_top;
  localparam int SETTLE = 8;
  logic clk = 0, rst = 1;
  logic bus_valid = 0, bus_write = 0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_rvalid;
  logic [31:0] bus_rdata;
  int checks = 0, failures = 0;
  bit done = 0;

  logic [31:0] mfuse [24];
  bit mlock [24];

  efuse_seq #(.SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata));

  always #5 clk = ~clk;

  function automatic logic [12:0] fa(int b);
    return 13'(32'h1000 + b * 4);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [12:0] a, logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 0; bus_write = 0;
  endtask

  task automatic rdreg(logic [12:0] a, output logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
    checks++;
    if (bus_rvalid !== 1'b1) begin
      failures++;
      $display("FAIL R11 actual=%b expected=1", bus_rvalid);
    end
    @(negedge clk); bus_valid = 0;
  endtask

  task automatic settle();
    repeat (SETTLE + 4) @(negedge clk);
  endtask

  task automatic expect_reg(string req, logic [12:0] a, logic [31:0] e);
    logic [31:0] v;
    rdreg(a, v);
    check(req, v, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    for (int i = 0; i < 24; i++) begin mfuse[i] = 0; mlock[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 0;

    expect_reg("R1 ctrl", 13'h20, 0);
    expect_reg("R1 err", 13'h24, 0);
    expect_reg("R1 key", 13'h2C, 0);
    expect_reg("R1 supply", 13'h54, 32'h2);

    wr(13'h2C, 32'hFFFF_8810);
    expect_reg("R2 key", 13'h2C, 32'h8810);
    wr(13'h20, 32'h1C);
    expect_reg("R2 ctrl", 13'h20, 32'h1C);

    // R4 burn with supply off
    wr(fa(72), 32'h1);
    expect_reg("R4 off err", 13'h24, 32'h1);
    wr(13'h20, 32'h1); settle();
    expect_reg("R4 off unchanged", fa(72), 0);
    wr(13'h28, 32'h3FFF);
    expect_reg("R10 full clear", 13'h24, 0);

    // R3 power-up sequence and busy window
    wr(13'h54, 32'h0); settle();
    wr(13'h54, 32'h5);
    expect_reg("R3 busy", 13'h54, 32'h8000_0005);
    wr(fa(72), 32'h10);
    expect_reg("R3 refused", 13'h24, 32'h1);
    settle();
    expect_reg("R3 idle", 13'h54, 32'h5);
    expect_reg("R3 unchanged", fa(72), 0);
    wr(13'h28, 32'h3FFF);

    // R5 OR burn
    wr(fa(72), 32'hA5A5_0000);
    expect_reg("R5 first", fa(72), 32'hA5A5_0000);
    wr(fa(72), 32'h0000_5A5A);
    expect_reg("R5 or", fa(72), 32'hA5A5_5A5A);
    expect_reg("R5 no err", 13'h24, 0);
    mfuse[0] = 32'hA5A5_5A5A;

    // R6 auto-check
    wr(13'h20, 32'h3);
    wr(fa(73), 32'h0F00);
    expect_reg("R6 clean", 13'h24, 0);
    wr(fa(73), 32'h00F0);
    expect_reg("R6 mismatch", 13'h24, 32'h4);
    expect_reg("R6 stored", fa(73), 32'h0FF0);
    mfuse[1] = 32'h0FF0;
    wr(13'h28, 32'h3FFF);

    // R7 lock
    wr(13'h20, 32'h13);
    wr(fa(74), 32'h1234);
    wr(13'h20, 32'h1);
    wr(fa(74), 32'h8000_0000);
    expect_reg("R7 locked err", 13'h24, 32'h2);
    expect_reg("R7 locked data", fa(74), 32'h1234);
    mfuse[2] = 32'h1234; mlock[2] = 1;
    wr(13'h28, 32'h3FFF);

    // R9 out-of-window blocks
    wr(fa(10), 32'hFFFF_FFFF);
    wr(fa(96), 32'hFFFF_FFFF);
    expect_reg("R9 low read", fa(10), 0);
    expect_reg("R9 high read", fa(96), 0);
    expect_reg("R9 no flag", 13'h24, 0);
    wr(fa(95), 32'h55);
    expect_reg("R9 top block", fa(95), 32'h55);
    mfuse[23] = 32'h55;

    // R8 read without supply, R10 partial clear
    wr(13'h20, 32'h0); settle();
    expect_reg("R8 no supply data", fa(72), 0);
    expect_reg("R8 no supply err", 13'h24, 32'h8);
    wr(13'h20, 32'h1); settle();
    expect_reg("R8 supply data", fa(72), 32'hA5A5_5A5A);
    wr(13'h2C, 32'h0);
    wr(fa(75), 32'h1);
    expect_reg("R4 key cleared", 13'h24, 32'h9);
    wr(13'h28, 32'h1);
    expect_reg("R10 partial", 13'h24, 32'h8);
    wr(13'h28, 32'h3FFF);
    expect_reg("R4 key cleared data", fa(75), 0);
    wr(13'h2C, 32'h8810);

    // random burns against model
    for (int it = 0; it < 60; it++) begin
      int b;
      bit ac, lk;
      logic [31:0] d, m, e;
      b  = int'($urandom_range(0, 23));
      ac = $urandom_range(0, 1);
      lk = ($urandom_range(0, 7) == 0);
      d  = $urandom;
      if ($urandom_range(0, 1)) d = d | mfuse[b];
      wr(13'h20, {27'b0, lk, 2'b0, ac, 1'b1});
      wr(fa(72 + b), d);
      e = 0;
      if (mlock[b]) e = 32'h2;
      else begin
        m = mfuse[b] | d;
        mfuse[b] = m;
        if (ac && m != d) e = 32'h4;
        else if (lk) mlock[b] = 1;
      end
      expect_reg("R7 R6 random err", 13'h24, e);
      expect_reg("R5 random data", fa(72 + b), mfuse[b]);
      wr(13'h28, 32'h3FFF);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule